// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block gives a host processor 24 general-purpose lines arranged as three byte-wide ports: A, B and C. Port C is split into an upper and a lower nibble. The lines form two groups of twelve. The first group holds port A and port C bits 7..4. The second group holds port B and port C bits 3..0. The host reaches the block through a small byte bus with a two-bit register select, a write strobe, a read strobe and separate write and read data. Writing to select 3 loads a control word. That word either reconfigures both groups or sets or clears one port C line.

Each group has its own operating mode. In the basic mode the ports are plain latched outputs or live inputs, and no handshake is used. In the strobed mode the group's byte port gets a peripheral handshake. Port C lines then carry the strobe, acknowledge, buffer-flag and interrupt-request signals. Incoming data is captured on the peripheral strobe, and outgoing data is held until the peripheral acknowledges it. Port A also has a bidirectional strobed mode that uses both handshakes at once, while group B continues in its own mode. Pads are modelled as separate in, out and output-enable signals. Peripheral-side inputs are sampled on the block clock, so they must already be synchronous to it.

The host bus has no back-pressure. A write or read strobe is accepted in the cycle it is high. Read data is combinational on the select and the current state. Any side effect of a read, such as clearing a flag, takes effect at the clock edge that ends the read cycle.

Top module: `pio_port`

## Requirements
- R1: After reset, every line is an input: `pa_oe`, `pb_oe` and `pc_oe` are all 0. Both groups are in basic mode, all output latches read 0, and `intr_a` and `intr_b` are 0.
- R2: A byte written to select 3 with bit 7 = 1 is a mode word. Bits 6..5 give the group A mode: 00 is basic, 01 is strobed, and 1x is bidirectional. Bit 4 gives port A direction, bit 3 port C upper direction, bit 2 the group B mode (0 basic, 1 strobed), bit 1 port B direction and bit 0 port C lower direction, with 1 meaning input. Every mode word clears all output latches, buffer flags, interrupt requests and interrupt enables.
- R3: In basic mode, a write to an output port (select 0 = A, 1 = B, 2 = C) drives that value on the port's `*_out` lines with output enable high, and a read of that port returns the written value.
- R4: In basic mode, a read of an input port returns the live pins. A write to an input port leaves its latch, seen on `*_out`, unchanged.
- R5: A byte written to select 3 with bit 7 = 0 changes only port C bit number wdata[3:1], setting it to wdata[0]. No other port C bit changes and the configuration is untouched.
- R6: Strobed input uses PC4 (port A) or PC2 (port B) as an active-low strobe. The strobe's falling edge latches the port pins and sets the buffer-full flag, shown on PC5 (A) or PC1 (B). A host read of the port returns the latched byte and clears the flag and the request.
- R7: The interrupt enables are written with the bit set/reset word aimed at a handshake input line: PC4 for the port A input side, PC6 for the port A output side, and PC2 for port B. A request (`intr_a` mirrored on PC3, `intr_b` on PC0) rises only if its enable is set: on the strobe's rising edge while the buffer is full, or on an acknowledge falling edge.
- R8: Strobed output uses PC6 (A) or PC2 (B) as an active-low acknowledge and shows an active-low buffer-full line on PC7 (A) or PC1 (B). A host write to the port drives that line low and clears the request. The acknowledge's falling edge drives it high again and raises the request if enabled.
- R9: In bidirectional mode, port A output enable is high exactly while PC6 is low. Both the input and output handshakes of R6 and R8 work on port A, sharing the request on PC3.
- R10: Handshake status lines (request, buffer flags) have output enable 1. Handshake input lines (strobe, acknowledge) have output enable 0. All other port C lines follow their nibble's direction bit.
- R11: If a strobe falling edge meets a host read of the same port in one cycle, the read returns the previous byte, the new byte is latched and the buffer flag stays set. If an acknowledge falling edge meets a host write in one cycle, the write wins: the buffer-full line stays low and the request stays clear.
- R12: A read of select 2 returns, for each port C line, the driven value of lines with output enable high and the pin of other lines. Handshake input lines read instead as their interrupt enable. Select 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C driven values |
| pc_oe | output | 8 | Port C per-line output enables |
| intr_a | output | 1 | Group A interrupt request |
| intr_b | output | 1 | Group B interrupt request |

## Verification
Two functions can fall in the same clock cycle. The first pair is a peripheral strobe falling edge and a host read of the same port. The bench provokes it by lowering PC4 and raising the read strobe on the same falling clock edge. It judges the result by three things: the returned byte must be the earlier capture, the buffer flag on PC5 must stay high, and a follow-up read must return the new pins. The second pair is an acknowledge falling edge and a host write. The bench lowers PC2 in the same cycle as a port B write, then requires PC1 to stay low and `intr_b` to stay clear.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int PORT_W = 8;

  // Port C line roles while a group runs a handshake
  localparam int PC_INT_B  = 0;
  localparam int PC_FLAG_B = 1;
  localparam int PC_HS_B   = 2;
  localparam int PC_INT_A  = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;

  typedef enum logic [1:0] {
    GM_BASIC    = 2'd0,
    GM_STROBED  = 2'd1,
    GM_BIDIR    = 2'd2
  } grp_mode_e;

  typedef struct packed {
    grp_mode_e a_mode;
    logic      a_in;
    logic      cu_in;
    logic      b_strobed;
    logic      b_in;
    logic      cl_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{a_mode: GM_BASIC, a_in: 1'b1, cu_in: 1'b1,
                                     b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic pio_cfg_t decode_mode_word(input logic [7:0] w);
    pio_cfg_t c;
    if (w[6])      c.a_mode = GM_BIDIR;
    else if (w[5]) c.a_mode = GM_STROBED;
    else           c.a_mode = GM_BASIC;
    c.a_in      = w[4];
    c.cu_in     = w[3];
    c.b_strobed = w[2];
    c.b_in      = w[1];
    c.cl_in     = w[0];
    return c;
  endfunction

  function automatic logic a_in_side(input pio_cfg_t c);
    return (c.a_mode == GM_BIDIR) || (c.a_mode == GM_STROBED && c.a_in);
  endfunction

  function automatic logic a_out_side(input pio_cfg_t c);
    return (c.a_mode == GM_BIDIR) || (c.a_mode == GM_STROBED && !c.a_in);
  endfunction

  // Port C lines taken over by handshake signalling
  function automatic logic [7:0] hs_owned(input pio_cfg_t c);
    logic [7:0] m;
    m = '0;
    if (a_in_side(c) || a_out_side(c)) m[PC_INT_A] = 1'b1;
    if (a_in_side(c))  begin m[PC_STB_A] = 1'b1; m[PC_IBF_A] = 1'b1; end
    if (a_out_side(c)) begin m[PC_ACK_A] = 1'b1; m[PC_OBF_A] = 1'b1; end
    if (c.b_strobed)   m[2:0] = 3'b111;
    return m;
  endfunction

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output pio_cfg_t   cfg_o,
  output logic [7:0] pc_latch_o,
  output logic       inte_a_in_o,
  output logic       inte_a_out_o,
  output logic       inte_b_o,
  output logic       mode_wr_o
);

  logic       bsr_wr, pc_wr;
  logic [2:0] bsr_idx;
  logic [7:0] owned;

  assign mode_wr_o = wr_en && (addr == 2'd3) && wdata[7];
  assign bsr_wr    = wr_en && (addr == 2'd3) && !wdata[7];
  assign pc_wr     = wr_en && (addr == 2'd2);
  assign bsr_idx   = wdata[3:1];
  assign owned     = hs_owned(cfg_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o        <= CFG_RESET;
      pc_latch_o   <= '0;
      inte_a_in_o  <= 1'b0;
      inte_a_out_o <= 1'b0;
      inte_b_o     <= 1'b0;
    end else if (mode_wr_o) begin
      cfg_o        <= decode_mode_word(wdata);
      pc_latch_o   <= '0;
      inte_a_in_o  <= 1'b0;
      inte_a_out_o <= 1'b0;
      inte_b_o     <= 1'b0;
    end else if (bsr_wr) begin
      if (owned[bsr_idx]) begin
        if (bsr_idx == 3'(PC_STB_A)) inte_a_in_o  <= wdata[0];
        if (bsr_idx == 3'(PC_ACK_A)) inte_a_out_o <= wdata[0];
        if (bsr_idx == 3'(PC_HS_B))  inte_b_o     <= wdata[0];
      end else begin
        pc_latch_o[bsr_idx] <= wdata[0];
      end
    end else if (pc_wr) begin
      pc_latch_o <= (pc_latch_o & owned) | (wdata & ~owned);
    end
  end

  // R2: a mode word leaves latch and enables cleared
  p_mode_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_o |=> (pc_latch_o == 8'h00) && !inte_a_in_o && !inte_a_out_o && !inte_b_o);

  // R5: a bit set/reset word moves at most one latch bit
  p_bsr_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $countones(pc_latch_o ^ $past(pc_latch_o)) <= 1);

  // R5: configuration untouched by a bit set/reset word
  p_bsr_cfg_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $stable(cfg_o));

endmodule

// File: rtl/pio_hs_chan.sv
module pio_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         in_side_i,
  input  logic         out_side_i,
  input  logic         stb_n_i,
  input  logic         ack_n_i,
  input  logic [W-1:0] data_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic         inte_in_i,
  input  logic         inte_out_i,
  output logic [W-1:0] data_q_o,
  output logic         ibf_o,
  output logic         obf_o,
  output logic         intr_o
);

  logic stb_q, ack_q;
  logic stb_fall, stb_rise, ack_fall, rd_hit, wr_hit;
  logic intr_in, intr_out;

  assign stb_fall = in_side_i && stb_q && !stb_n_i;
  assign stb_rise = in_side_i && !stb_q && stb_n_i;
  assign ack_fall = out_side_i && ack_q && !ack_n_i;
  assign rd_hit   = rd_i && in_side_i;
  assign wr_hit   = wr_i && out_side_i;
  assign intr_o   = intr_in || intr_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      ack_q <= 1'b1;
    end else begin
      stb_q <= stb_n_i;
      ack_q <= ack_n_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      data_q_o <= '0;
      ibf_o    <= 1'b0;
      obf_o    <= 1'b0;
      intr_in  <= 1'b0;
      intr_out <= 1'b0;
    end else begin
      // input side: a new capture outranks the read that would empty it
      if (stb_fall) begin
        data_q_o <= data_i;
        ibf_o    <= 1'b1;
      end else if (rd_hit) begin
        ibf_o    <= 1'b0;
      end
      if (rd_hit)
        intr_in <= 1'b0;
      else if (stb_rise && ibf_o && inte_in_i)
        intr_in <= 1'b1;
      // output side: host write outranks the acknowledge
      if (wr_hit) begin
        obf_o    <= 1'b1;
        intr_out <= 1'b0;
      end else if (ack_fall) begin
        obf_o    <= 1'b0;
        intr_out <= inte_out_i;
      end
    end
  end

  p_stb_latches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall && !clr_i |=> ibf_o && (data_q_o == $past(data_i)));

  p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && !stb_fall && !clr_i |=> !ibf_o && !intr_in);

  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !clr_i |=> obf_o && !intr_out);

  p_ack_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall && !wr_hit && !clr_i |=> !obf_o);

  p_intr_needs_inte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_in) |-> $past(inte_in_i));

  p_clr_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ibf_o && !obf_o && !intr_o);

endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe,
  output logic       intr_a,
  output logic       intr_b
);

  localparam int PW     = PORT_W;
  localparam int N_CHAN = 2;

  pio_cfg_t   cfg;
  logic [7:0] pc_latch;
  logic       inte_a_in, inte_a_out, inte_b, mode_wr;
  logic       a_in_s, a_out_s, b_in_s, b_out_s, a_drives;
  logic       sel_a, sel_b;
  logic [PW-1:0] pa_latch, pb_latch;
  logic [7:0] pc_view;

  logic [N_CHAN-1:0] ch_in_side, ch_out_side, ch_stb, ch_ack, ch_rd, ch_wr;
  logic [N_CHAN-1:0] ch_inte_in, ch_inte_out, ch_ibf, ch_obf, ch_intr;
  logic [PW-1:0]     ch_din [N_CHAN];
  logic [PW-1:0]     ch_q   [N_CHAN];

  pio_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cpu_wr),
    .addr        (cpu_addr),
    .wdata       (cpu_wdata),
    .cfg_o       (cfg),
    .pc_latch_o  (pc_latch),
    .inte_a_in_o (inte_a_in),
    .inte_a_out_o(inte_a_out),
    .inte_b_o    (inte_b),
    .mode_wr_o   (mode_wr)
  );

  assign a_in_s   = a_in_side(cfg);
  assign a_out_s  = a_out_side(cfg);
  assign b_in_s   = cfg.b_strobed && cfg.b_in;
  assign b_out_s  = cfg.b_strobed && !cfg.b_in;
  assign a_drives = !cfg.a_in || (cfg.a_mode == GM_BIDIR);
  assign sel_a    = (cpu_addr == 2'd0);
  assign sel_b    = (cpu_addr == 2'd1);

  // channel 0 serves port A, channel 1 serves port B
  assign ch_in_side  = {b_in_s, a_in_s};
  assign ch_out_side = {b_out_s, a_out_s};
  assign ch_stb      = {pc_in[PC_HS_B], pc_in[PC_STB_A]};
  assign ch_ack      = {pc_in[PC_HS_B], pc_in[PC_ACK_A]};
  assign ch_rd       = {cpu_rd && sel_b, cpu_rd && sel_a};
  assign ch_wr       = {cpu_wr && sel_b, cpu_wr && sel_a};
  assign ch_inte_in  = {inte_b, inte_a_in};
  assign ch_inte_out = {inte_b, inte_a_out};
  assign ch_din[0]   = pa_in;
  assign ch_din[1]   = pb_in;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    pio_hs_chan #(.W(PW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (mode_wr),
      .in_side_i (ch_in_side[g]),
      .out_side_i(ch_out_side[g]),
      .stb_n_i   (ch_stb[g]),
      .ack_n_i   (ch_ack[g]),
      .data_i    (ch_din[g]),
      .rd_i      (ch_rd[g]),
      .wr_i      (ch_wr[g]),
      .inte_in_i (ch_inte_in[g]),
      .inte_out_i(ch_inte_out[g]),
      .data_q_o  (ch_q[g]),
      .ibf_o     (ch_ibf[g]),
      .obf_o     (ch_obf[g]),
      .intr_o    (ch_intr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mode_wr) begin
      pa_latch <= '0;
      pb_latch <= '0;
    end else begin
      if (cpu_wr && sel_a && a_drives) pa_latch <= cpu_wdata;
      if (cpu_wr && sel_b && !cfg.b_in) pb_latch <= cpu_wdata;
    end
  end

  assign pa_out = pa_latch;
  assign pb_out = pb_latch;
  assign pa_oe  = (cfg.a_mode == GM_BIDIR) ? !pc_in[PC_ACK_A] : !cfg.a_in;
  assign pb_oe  = !cfg.b_in;
  assign intr_a = ch_intr[0];
  assign intr_b = ch_intr[1];

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      pc_out[i] = pc_latch[i];
      pc_oe[i]  = (i >= 4) ? !cfg.cu_in : !cfg.cl_in;
    end
    if (a_in_s || a_out_s) begin
      pc_out[PC_INT_A] = ch_intr[0];
      pc_oe[PC_INT_A]  = 1'b1;
    end
    if (a_in_s) begin
      pc_out[PC_IBF_A] = ch_ibf[0];
      pc_oe[PC_IBF_A]  = 1'b1;
      pc_out[PC_STB_A] = 1'b0;
      pc_oe[PC_STB_A]  = 1'b0;
    end
    if (a_out_s) begin
      pc_out[PC_OBF_A] = !ch_obf[0];
      pc_oe[PC_OBF_A]  = 1'b1;
      pc_out[PC_ACK_A] = 1'b0;
      pc_oe[PC_ACK_A]  = 1'b0;
    end
    if (cfg.b_strobed) begin
      pc_out[PC_INT_B]  = ch_intr[1];
      pc_oe[PC_INT_B]   = 1'b1;
      pc_out[PC_FLAG_B] = cfg.b_in ? ch_ibf[1] : !ch_obf[1];
      pc_oe[PC_FLAG_B]  = 1'b1;
      pc_out[PC_HS_B]   = 1'b0;
      pc_oe[PC_HS_B]    = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++)
      pc_view[i] = pc_oe[i] ? pc_out[i] : pc_in[i];
    if (a_in_s)        pc_view[PC_STB_A] = inte_a_in;
    if (a_out_s)       pc_view[PC_ACK_A] = inte_a_out;
    if (cfg.b_strobed) pc_view[PC_HS_B]  = inte_b;
  end

  always_comb begin
    unique case (cpu_addr)
      2'd0:    cpu_rdata = a_in_s ? ch_q[0] : (a_drives ? pa_latch : pa_in);
      2'd1:    cpu_rdata = b_in_s ? ch_q[1] : (!cfg.b_in ? pb_latch : pb_in);
      2'd2:    cpu_rdata = pc_view;
      default: cpu_rdata = 8'h00;
    endcase
  end

  // R4: writing port A while it is a basic input leaves its latch alone
  p_input_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && sel_a && cfg.a_mode == GM_BASIC && cfg.a_in |=> $stable(pa_out));

  // R9: in bidirectional mode the latch holds while no host write arrives
  p_bidir_latch_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.a_mode == GM_BIDIR && !(cpu_wr && (sel_a || cpu_addr == 2'd3)) |=> $stable(pa_out));

  // R10: strobe and acknowledge lines are never driven when a handshake owns them
  p_hs_inputs_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_in_s && pc_oe[PC_STB_A]) && !(a_out_s && pc_oe[PC_ACK_A]) && !(cfg.b_strobed && pc_oe[PC_HS_B]));

endmodule

// File: tb/tb_pio_port.sv
module tb_pio_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe, intr_a, intr_b;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  pio_port dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .intr_a(intr_a), .intr_b(intr_b)
  );

  // {kind, select, wdata, pa pins, pb pins, expected}; kind 0 write, 1 read, 2 output
  localparam int NV = 23;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 2'd3, 8'h80, 8'h00, 8'h00, 8'h00},
    {2'd0, 2'd0, 8'h5A, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd0, 8'h00, 8'h00, 8'h00, 8'h5A},
    {2'd0, 2'd1, 8'hC3, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd1, 8'h00, 8'h00, 8'h00, 8'hC3},
    {2'd1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h5A},
    {2'd0, 2'd2, 8'h96, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h00, 8'h96},
    {2'd0, 2'd3, 8'h01, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h00, 8'h97},
    {2'd0, 2'd3, 8'h0E, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h00, 8'h17},
    {2'd0, 2'd3, 8'h9B, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h3C},
    {2'd1, 2'd1, 8'h00, 8'h00, 8'hA5, 8'hA5},
    {2'd0, 2'd0, 8'hFF, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hFF},
    {2'd0, 2'd3, 8'h8A, 8'h00, 8'h00, 8'h00},
    {2'd0, 2'd2, 8'h5C, 8'h00, 8'h00, 8'h00},
    {2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hFC}
  };
  // requirement named by each vector row
  localparam string VREQ [NV] = '{
    "R2", "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R5", "R5", "R5", "R5",
    "R2", "R2", "R2", "R4", "R4", "R4", "R4", "R12", "R2", "R12", "R12"};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #2 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {5'd0, pa_oe, pb_oe, intr_a | intr_b}, 8'h00);
    check("R1", pc_oe, 8'h00);
    check("R1", pa_out | pb_out, 8'h00);

    // table walk: basic mode, bit set/reset, mode word clearing
    for (int k = 0; k < NV; k++) begin
      logic [35:0] v;
      v = VEC[k];
      pa_in = v[23:16];
      pb_in = v[15:8];
      case (v[35:34])
        2'd0: bus_wr(v[33:32], v[31:24]);
        2'd1: begin bus_rd(v[33:32], rv); check(VREQ[k], rv, v[7:0]); end
        default: begin
          @(negedge clk); #2;
          case (v[33:32])
            2'd0: check(VREQ[k], pa_out, v[7:0]);
            2'd1: check(VREQ[k], pb_out, v[7:0]);
            default: check(VREQ[k], pc_out, v[7:0]);
          endcase
        end
      endcase
    end

    // group A strobed input
    bus_wr(2'd3, 8'hB0);
    check("R10", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h09);                 // R7 enable via PC4
    pa_in = 8'h77; pc_in[4] = 1'b0;
    @(negedge clk);
    check("R6", {7'd0, pc_out[5]}, 8'h01);
    check("R7", {7'd0, intr_a}, 8'h00);
    pa_in = 8'h11; pc_in[4] = 1'b1;
    @(negedge clk);
    check("R7", {7'd0, intr_a}, 8'h01);
    bus_rd(2'd2, rv);
    check("R12", rv, 8'h38);
    bus_rd(2'd0, rv);
    check("R6", rv, 8'h77);
    check("R6", {6'd0, pc_out[5], intr_a}, 8'h00);

    // R11 strobe fall together with host read
    pa_in = 8'h44; pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk);
    cpu_addr = 2'd0; cpu_rd = 1'b1; pc_in[4] = 1'b0; pa_in = 8'h22;
    #2 rv = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
    check("R11", rv, 8'h44);
    check("R11", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1'b1;
    bus_rd(2'd0, rv);
    check("R11", rv, 8'h22);

    // R7 enable cleared: no request
    bus_wr(2'd3, 8'h08);
    pa_in = 8'h66; pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7", {6'd0, pc_out[5], intr_a}, 8'h02);

    // group B strobed output
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'h3E);
    check("R8", pb_out, 8'h3E);
    check("R8", {6'd0, pc_out[1], pb_oe}, 8'h01);
    pc_in[2] = 1'b0;
    @(negedge clk);
    check("R8", {6'd0, pc_out[1], intr_b}, 8'h03);
    check("R7", {7'd0, pc_out[0]}, 8'h01);
    pc_in[2] = 1'b1;
    @(negedge clk);
    // R11 acknowledge fall together with host write
    cpu_addr = 2'd1; cpu_wdata = 8'h9D; cpu_wr = 1'b1; pc_in[2] = 1'b0;
    @(negedge clk); cpu_wr = 1'b0;
    check("R11", {6'd0, pc_out[1], intr_b}, 8'h00);
    pc_in[2] = 1'b1;

    // R9 bidirectional port A
    bus_wr(2'd3, 8'hC0);
    check("R2", {6'd0, intr_b, pa_oe}, 8'h00);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd0, 8'h81);
    check("R9", {6'd0, pc_out[7], pa_oe}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0; #2;
    check("R9", {pa_oe, pa_out[6:0]}, 8'h81);
    @(negedge clk);
    check("R9", {6'd0, pc_out[7], intr_a}, 8'h03);
    pc_in[6] = 1'b1; #2;
    check("R9", {7'd0, pa_oe}, 8'h00);
    pa_in = 8'h5D; pc_in[4] = 1'b0;
    @(negedge clk); pc_in[4] = 1'b1;
    check("R9", {7'd0, pc_out[5]}, 8'h01);
    bus_rd(2'd0, rv);
    check("R9", rv, 8'h5D);
    bus_wr(2'd3, 8'hC0);
    check("R2", {6'd0, pc_out[7], intr_a}, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule